// File: doc/BRIEF.md
# SDRAM Open-Page Command Sequencer

This block sits between an internal bus and one SDRAM device. It accepts one read or write request at a time and turns it into the pin-level command stream the memory expects. After each access the row stays open. A later request to the same row then needs only a column command. A request to a different row first closes the open row, then opens the new one. Column commands never ask the device to auto-precharge.

The sequencer enforces the row-to-column delay, the precharge recovery time and the refresh recovery time as parameters. It also tracks CAS latency, so it can flag the cycle in which read data appears on the data bus. A refresh-interval timer reloads from a programmable divider input. When the timer expires, the sequencer holds off new accesses. If a row is open it closes all rows, then issues an auto-refresh. After the refresh, no row is considered open.

The requester holds the request lines steady until it sees a one-cycle acknowledge. The acknowledge coincides with the column command on the SDRAM bus.

Top module: `sdram_page_seq`

## Requirements
- R1: After reset the bus carries NOP, and req_ack, rd_valid and sd_dq_oe are all low. No row is open.
- R2: A request whose row equals the open row issues its READ or WRITE in the first cycle after the request is presented. No ACTIVATE or PRECHARGE is issued for it.
- R3: A request to a different row while a row is open issues PRECHARGE with address bit 10 low in the next cycle. ACTIVATE of the new row follows exactly T_RP cycles later, and the column command exactly T_RCD cycles after the ACTIVATE.
- R4: A request while no row is open issues ACTIVATE in the next cycle, with no PRECHARGE.
- R5: The column command never follows its ACTIVATE by fewer than T_RCD cycles. The sequencer uses exactly T_RCD.
- R6: rd_valid is high exactly CAS_LAT cycles after each READ command. In that cycle rd_data equals sd_dq_in.
- R7: During a WRITE command, sd_dq_oe is high and sd_dq_out carries the request's write data. sd_dq_oe is low in every other cycle.
- R8: The request address is {row, column}, with the column in req_addr[COL_W-1:0] and the row above it. ACTIVATE drives the row on sd_addr. READ and WRITE drive the zero-extended column with sd_addr[10] forced low.
- R9: The refresh timer expires every ref_div+1 cycles. Each expiry produces exactly one AUTO-REFRESH.
- R10: When a refresh is due with a row open, the sequencer issues PRECHARGE with sd_addr[10] high, then AUTO-REFRESH T_RP cycles later. The bus then carries only NOP for T_RFC-1 cycles. After the refresh no row is open, so the next access starts with ACTIVATE and no PRECHARGE.
- R11: A request presented while a refresh is pending waits for the refresh. Its ACTIVATE comes exactly T_RFC cycles after the AUTO-REFRESH.
- R12: req_ack is high for one cycle per request, exactly in the cycle of that request's READ or WRITE. A WRITE appears only for a write request.
- R13: Commands are encoded on {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} as ACTIVATE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO-REFRESH 0001 and NOP 0111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_div | input | DIV_W | Refresh interval; timer period is ref_div+1 cycles |
| req_valid | input | 1 | Request present; held until req_ack |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | {row, column} address |
| req_wdata | input | DATA_W | Write data |
| req_ack | output | 1 | One-cycle pulse with the request's column command |
| rd_valid | output | 1 | Read data valid this cycle |
| rd_data | output | DATA_W | Read data, taken from sd_dq_in |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ROW_W | SDRAM address bus |
| sd_dq_out | output | DATA_W | Data driven toward the SDRAM |
| sd_dq_oe | output | 1 | Output enable for sd_dq_out |
| sd_dq_in | input | DATA_W | Data returned by the SDRAM |

## Verification
The bench aims at the three paths a request can take: page hit, page miss and empty bank. It times each command against the cycle in which the request was presented. A sequencer that misjudged a hit would insert a needless ACTIVATE, and one that skipped the precharge on a miss would ACTIVATE over an open row. A row address with bit 10 set exposes a column command that leaks the row's A10 value into auto-precharge. The bench places a request exactly in the cycle a refresh becomes pending. A controller that let the access win would ACTIVATE before the AUTO-REFRESH. It also checks that a refresh over an open row uses an all-bank PRECHARGE and leaves the row closed, so a stale open-row flag shows up as a missing ACTIVATE.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

   typedef enum logic [3:0] {
      CMD_ACT = 4'b0011,
      CMD_RD  = 4'b0101,
      CMD_WR  = 4'b0100,
      CMD_PRE = 4'b0010,
      CMD_REF = 4'b0001,
      CMD_NOP = 4'b0111
   } sd_cmd_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ACT,
      ST_COL,
      ST_REF
   } seq_state_e;

   localparam int A10_BIT = 10;

endpackage

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
   parameter int GAP_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [GAP_W-1:0] load_val,
   output logic             busy
);

   logic [GAP_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign busy = (cnt != '0);

endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   input  logic             clear,
   output logic             pending
);

   logic [DIV_W-1:0] cnt;
   logic             expire;

   assign expire = (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt     <= div;
         pending <= 1'b0;
      end else begin
         cnt     <= expire ? div : cnt - 1'b1;
         pending <= expire | (pending & ~clear);
      end
   end

endmodule

// File: rtl/sdram_rd_return.sv
module sdram_rd_return #(
   parameter int CAS_LAT = 2,
   parameter int DATA_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_issued,
   input  logic [DATA_W-1:0] dq_in,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);

   logic tap;

   generate
      if (CAS_LAT == 1) begin : g_single
         logic stage;
         always_ff @(posedge clk) begin
            if (!rst_n) stage <= 1'b0;
            else        stage <= rd_issued;
         end
         assign tap = stage;
      end else begin : g_chain
         logic [CAS_LAT-1:0] stage;
         always_ff @(posedge clk) begin
            if (!rst_n) stage <= '0;
            else        stage <= {stage[CAS_LAT-2:0], rd_issued};
         end
         assign tap = stage[CAS_LAT-1];
      end
   endgenerate

   assign rd_valid = tap;
   assign rd_data  = tap ? dq_in : '0;

endmodule

// File: rtl/sdram_cmd_fsm.sv
module sdram_cmd_fsm
   import sdram_seq_pkg::*;
#(
   parameter int ROW_W  = 12,
   parameter int COL_W  = 8,
   parameter int DATA_W = 16,
   parameter int GAP_W  = 3,
   parameter int T_RCD  = 2,
   parameter int T_RP   = 2,
   parameter int T_RFC  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ROW_W-1:0]  req_row,
   input  logic [COL_W-1:0]  req_col,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              gap_busy,
   input  logic              ref_pending,
   output logic              gap_load,
   output logic [GAP_W-1:0]  gap_val,
   output logic              ref_clear,
   output sd_cmd_e           cmd_q,
   output logic [ROW_W-1:0]  addr_q,
   output logic [DATA_W-1:0] dq_q,
   output logic              oe_q,
   output logic              ack_q
);

   localparam logic [GAP_W-1:0] GAP_RCD = GAP_W'(T_RCD - 1);
   localparam logic [GAP_W-1:0] GAP_RP  = GAP_W'(T_RP - 1);
   localparam logic [GAP_W-1:0] GAP_RFC = GAP_W'(T_RFC - 1);

   seq_state_e        state, nxt_state;
   sd_cmd_e           nxt_cmd;
   logic [ROW_W-1:0]  nxt_addr;
   logic [DATA_W-1:0] nxt_dq;
   logic              nxt_oe, nxt_ack;

   logic              row_open;
   logic [ROW_W-1:0]  open_row;
   logic              open_set, open_clr;
   logic [ROW_W-1:0]  open_val;

   logic              take;
   logic              acc_write;
   logic [ROW_W-1:0]  acc_row;
   logic [COL_W-1:0]  acc_col;
   logic [DATA_W-1:0] acc_wdata;

   function automatic logic [ROW_W-1:0] col_addr(input logic [COL_W-1:0] c);
      logic [ROW_W-1:0] a;
      a            = '0;
      a[COL_W-1:0] = c;
      a[A10_BIT]   = 1'b0;
      return a;
   endfunction

   always_comb begin
      nxt_state = state;
      nxt_cmd   = CMD_NOP;
      nxt_addr  = '0;
      nxt_dq    = '0;
      nxt_oe    = 1'b0;
      nxt_ack   = 1'b0;
      gap_load  = 1'b0;
      gap_val   = '0;
      ref_clear = 1'b0;
      take      = 1'b0;
      open_set  = 1'b0;
      open_clr  = 1'b0;
      open_val  = acc_row;
      unique case (state)
         ST_IDLE: begin
            if (!gap_busy) begin
               if (ref_pending) begin
                  if (row_open) begin
                     nxt_cmd           = CMD_PRE;
                     nxt_addr[A10_BIT] = 1'b1;
                     gap_load          = 1'b1;
                     gap_val           = GAP_RP;
                     nxt_state         = ST_REF;
                  end else begin
                     nxt_cmd   = CMD_REF;
                     ref_clear = 1'b1;
                     gap_load  = 1'b1;
                     gap_val   = GAP_RFC;
                  end
               end else if (req_valid && !ack_q) begin
                  take = 1'b1;
                  if (row_open && (req_row == open_row)) begin
                     nxt_cmd  = req_write ? CMD_WR : CMD_RD;
                     nxt_addr = col_addr(req_col);
                     nxt_dq   = req_write ? req_wdata : '0;
                     nxt_oe   = req_write;
                     nxt_ack  = 1'b1;
                  end else if (row_open) begin
                     nxt_cmd   = CMD_PRE;
                     gap_load  = 1'b1;
                     gap_val   = GAP_RP;
                     open_clr  = 1'b1;
                     nxt_state = ST_ACT;
                  end else begin
                     nxt_cmd   = CMD_ACT;
                     nxt_addr  = req_row;
                     gap_load  = 1'b1;
                     gap_val   = GAP_RCD;
                     open_set  = 1'b1;
                     open_val  = req_row;
                     nxt_state = ST_COL;
                  end
               end
            end
         end
         ST_ACT: begin
            if (!gap_busy) begin
               nxt_cmd   = CMD_ACT;
               nxt_addr  = acc_row;
               gap_load  = 1'b1;
               gap_val   = GAP_RCD;
               open_set  = 1'b1;
               open_val  = acc_row;
               nxt_state = ST_COL;
            end
         end
         ST_COL: begin
            if (!gap_busy) begin
               nxt_cmd   = acc_write ? CMD_WR : CMD_RD;
               nxt_addr  = col_addr(acc_col);
               nxt_dq    = acc_write ? acc_wdata : '0;
               nxt_oe    = acc_write;
               nxt_ack   = 1'b1;
               nxt_state = ST_IDLE;
            end
         end
         ST_REF: begin
            if (!gap_busy) begin
               nxt_cmd   = CMD_REF;
               ref_clear = 1'b1;
               gap_load  = 1'b1;
               gap_val   = GAP_RFC;
               open_clr  = 1'b1;
               nxt_state = ST_IDLE;
            end
         end
         default: nxt_state = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cmd_q     <= CMD_NOP;
         addr_q    <= '0;
         dq_q      <= '0;
         oe_q      <= 1'b0;
         ack_q     <= 1'b0;
         row_open  <= 1'b0;
         open_row  <= '0;
         acc_write <= 1'b0;
         acc_row   <= '0;
         acc_col   <= '0;
         acc_wdata <= '0;
      end else begin
         state  <= nxt_state;
         cmd_q  <= nxt_cmd;
         addr_q <= nxt_addr;
         dq_q   <= nxt_dq;
         oe_q   <= nxt_oe;
         ack_q  <= nxt_ack;
         if (open_set) begin
            row_open <= 1'b1;
            open_row <= open_val;
         end else if (open_clr) begin
            row_open <= 1'b0;
         end
         if (take) begin
            acc_write <= req_write;
            acc_row   <= req_row;
            acc_col   <= req_col;
            acc_wdata <= req_wdata;
         end
      end
   end

endmodule

// File: rtl/sdram_page_seq.sv
module sdram_page_seq
   import sdram_seq_pkg::*;
#(
   parameter int ROW_W   = 12,
   parameter int COL_W   = 8,
   parameter int DATA_W  = 16,
   parameter int DIV_W   = 16,
   parameter int T_RCD   = 2,
   parameter int T_RP    = 2,
   parameter int T_RFC   = 6,
   parameter int CAS_LAT = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [DIV_W-1:0]         ref_div,
   input  logic                     req_valid,
   input  logic                     req_write,
   input  logic [ROW_W+COL_W-1:0]   req_addr,
   input  logic [DATA_W-1:0]        req_wdata,
   output logic                     req_ack,
   output logic                     rd_valid,
   output logic [DATA_W-1:0]        rd_data,
   output logic                     sd_cs_n,
   output logic                     sd_ras_n,
   output logic                     sd_cas_n,
   output logic                     sd_we_n,
   output logic [ROW_W-1:0]         sd_addr,
   output logic [DATA_W-1:0]        sd_dq_out,
   output logic                     sd_dq_oe,
   input  logic [DATA_W-1:0]        sd_dq_in
);

   localparam int T_MAX1 = (T_RCD > T_RP) ? T_RCD : T_RP;
   localparam int T_MAX  = (T_MAX1 > T_RFC) ? T_MAX1 : T_RFC;
   localparam int GAP_W  = $clog2(T_MAX + 1);

   generate
      if (ROW_W <= A10_BIT) begin : g_bad_row
         $error("ROW_W must be at least 11 so the address bus carries A10");
      end
      if (COL_W > A10_BIT) begin : g_bad_col
         $error("COL_W must not exceed 10 so columns sit below A10");
      end
      if (T_RCD < 1 || T_RP < 1 || T_RFC < 1) begin : g_bad_timing
         $error("timing parameters must be at least 1");
      end
      if (CAS_LAT < 1) begin : g_bad_cl
         $error("CAS_LAT must be at least 1");
      end
   endgenerate

   logic              gap_load, gap_busy;
   logic [GAP_W-1:0]  gap_val;
   logic              ref_clear, ref_pending;
   sd_cmd_e           cmd_q;
   logic [ROW_W-1:0]  req_row;
   logic [COL_W-1:0]  req_col;

   assign req_row = req_addr[COL_W +: ROW_W];
   assign req_col = req_addr[COL_W-1:0];

   sdram_gap_timer #(.GAP_W(GAP_W)) u_gap (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (gap_load),
      .load_val (gap_val),
      .busy     (gap_busy)
   );

   sdram_refresh_timer #(.DIV_W(DIV_W)) u_ref (
      .clk     (clk),
      .rst_n   (rst_n),
      .div     (ref_div),
      .clear   (ref_clear),
      .pending (ref_pending)
   );

   sdram_cmd_fsm #(
      .ROW_W  (ROW_W),
      .COL_W  (COL_W),
      .DATA_W (DATA_W),
      .GAP_W  (GAP_W),
      .T_RCD  (T_RCD),
      .T_RP   (T_RP),
      .T_RFC  (T_RFC)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_write   (req_write),
      .req_row     (req_row),
      .req_col     (req_col),
      .req_wdata   (req_wdata),
      .gap_busy    (gap_busy),
      .ref_pending (ref_pending),
      .gap_load    (gap_load),
      .gap_val     (gap_val),
      .ref_clear   (ref_clear),
      .cmd_q       (cmd_q),
      .addr_q      (sd_addr),
      .dq_q        (sd_dq_out),
      .oe_q        (sd_dq_oe),
      .ack_q       (req_ack)
   );

   sdram_rd_return #(.CAS_LAT(CAS_LAT), .DATA_W(DATA_W)) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_issued (cmd_q == CMD_RD),
      .dq_in     (sd_dq_in),
      .rd_valid  (rd_valid),
      .rd_data   (rd_data)
   );

   assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;

endmodule

// File: rtl/sdram_page_seq_chk.sv
module sdram_page_seq_chk
   import sdram_seq_pkg::*;
#(
   parameter int T_RCD = 2,
   parameter int T_RP  = 2,
   parameter int T_RFC = 6
) (
   input logic clk,
   input logic rst_n,
   input logic req_ack,
   input logic sd_cs_n,
   input logic sd_ras_n,
   input logic sd_cas_n,
   input logic sd_we_n,
   input logic col_a10,
   input logic sd_dq_oe
);

   logic [3:0]  cmd;
   logic        is_col;
   logic [15:0] since_act, since_pre, since_ref;
   logic        seen_act, seen_pre, seen_ref;

   assign cmd    = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
   assign is_col = (cmd == CMD_RD) || (cmd == CMD_WR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_act <= '0;
         since_pre <= '0;
         since_ref <= '0;
         seen_act  <= 1'b0;
         seen_pre  <= 1'b0;
         seen_ref  <= 1'b0;
      end else begin
         if (cmd == CMD_ACT) begin
            since_act <= 16'd1;
            seen_act  <= 1'b1;
         end else if (since_act != 16'hFFFF) begin
            since_act <= since_act + 16'd1;
         end
         if (cmd == CMD_PRE) begin
            since_pre <= 16'd1;
            seen_pre  <= 1'b1;
         end else if (since_pre != 16'hFFFF) begin
            since_pre <= since_pre + 16'd1;
         end
         if (cmd == CMD_REF) begin
            since_ref <= 16'd1;
            seen_ref  <= 1'b1;
         end else if (since_ref != 16'hFFFF) begin
            since_ref <= since_ref + 16'd1;
         end
      end
   end

   AST_COL_A10_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      is_col |-> !col_a10); // R8

   AST_WR_DRIVES_DQ: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_WR) |-> sd_dq_oe); // R7

   AST_DQ_ONLY_ON_WR: assert property (@(posedge clk) disable iff (!rst_n)
      sd_dq_oe |-> (cmd == CMD_WR)); // R7

   AST_ACK_WITH_COL: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack |-> is_col); // R12

   AST_COL_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      is_col |-> req_ack); // R12

   AST_RCD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      is_col |-> (seen_act && since_act >= 16'(T_RCD))); // R5

   AST_RP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmd == CMD_ACT || cmd == CMD_REF) && seen_pre) |-> (since_pre >= 16'(T_RP))); // R3

   AST_RFC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_ref && since_ref < 16'(T_RFC)) |-> (cmd == CMD_NOP)); // R10

endmodule

bind sdram_page_seq sdram_page_seq_chk #(
   .T_RCD (T_RCD),
   .T_RP  (T_RP),
   .T_RFC (T_RFC)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_ack  (req_ack),
   .sd_cs_n  (sd_cs_n),
   .sd_ras_n (sd_ras_n),
   .sd_cas_n (sd_cas_n),
   .sd_we_n  (sd_we_n),
   .col_a10  (sd_addr[10]),
   .sd_dq_oe (sd_dq_oe)
);

// File: tb/sim_sdram_page_seq.sv
module sim_sdram_page_seq;

   localparam int ROW_W = 12;
   localparam int COL_W = 8;
   localparam int DW    = 16;
   localparam int DIV_W = 16;
   localparam int TRCD  = 2;
   localparam int TRP   = 2;
   localparam int TRFC  = 6;
   localparam int CL    = 2;
   localparam int REF_D = 40;

   localparam logic [3:0] C_ACT = 4'b0011;
   localparam logic [3:0] C_RD  = 4'b0101;
   localparam logic [3:0] C_WR  = 4'b0100;
   localparam logic [3:0] C_PRE = 4'b0010;
   localparam logic [3:0] C_REF = 4'b0001;
   localparam logic [3:0] C_NOP = 4'b0111;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic                   rst_n = 1'b0;
   logic [DIV_W-1:0]       ref_div = 16'd60000;
   logic                   req_valid = 1'b0;
   logic                   req_write = 1'b0;
   logic [ROW_W+COL_W-1:0] req_addr = '0;
   logic [DW-1:0]          req_wdata = '0;
   logic                   req_ack, rd_valid, sd_dq_oe;
   logic [DW-1:0]          rd_data, sd_dq_out, sd_dq_in;
   logic                   sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
   logic [ROW_W-1:0]       sd_addr;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;
   assign sd_dq_in = 16'hA500 + 16'(cyc);

   sdram_page_seq #(
      .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DW), .DIV_W(DIV_W),
      .T_RCD(TRCD), .T_RP(TRP), .T_RFC(TRFC), .CAS_LAT(CL)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .ref_div(ref_div),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_ack(req_ack), .rd_valid(rd_valid),
      .rd_data(rd_data), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
      .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr),
      .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
   );

   logic [3:0] bus_cmd;
   assign bus_cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

   int n_tests = 0, n_fail = 0;
   int n_act, n_pre, n_ref, n_col, n_ack, n_rv, oe_bad, ack_bad, rfc_bad;
   int t_act, t_pre, t_ref = -1000, t_ref_prev = -1000, t_col, t_ack, t_rv;
   logic [ROW_W-1:0] a_act, a_col;
   logic             a10_pre, oe_wr;
   logic [3:0]       c_col;
   logic [DW-1:0]    d_wr, d_rd;

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (bus_cmd != C_NOP && bus_cmd != C_REF && (cyc - t_ref) < TRFC) rfc_bad++;
         if (sd_dq_oe && bus_cmd != C_WR) oe_bad++;
         if (req_ack != (bus_cmd == C_RD || bus_cmd == C_WR)) ack_bad++;
         case (bus_cmd)
            C_ACT: begin n_act++; t_act = cyc; a_act = sd_addr; end
            C_PRE: begin n_pre++; t_pre = cyc; a10_pre = sd_addr[10]; end
            C_REF: begin n_ref++; t_ref_prev = t_ref; t_ref = cyc; end
            C_RD, C_WR: begin
               n_col++; t_col = cyc; a_col = sd_addr; c_col = bus_cmd;
               if (bus_cmd == C_WR) begin d_wr = sd_dq_out; oe_wr = sd_dq_oe; end
            end
            default: ;
         endcase
         if (req_ack) begin n_ack++; t_ack = cyc; end
         if (rd_valid) begin n_rv++; t_rv = cyc; d_rd = rd_data; end
      end
      if (cyc > 20000) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog (all requirements): actual cycle %0d expected below 20000", cyc);
         summary();
         $finish;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic clear_mon();
      n_act = 0; n_pre = 0; n_ref = 0; n_col = 0; n_ack = 0; n_rv = 0;
      oe_bad = 0; ack_bad = 0; rfc_bad = 0;
   endtask

   task automatic do_reset(input logic [DIV_W-1:0] div);
      @(negedge clk);
      rst_n = 1'b0; ref_div = div;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1 clear_mon();
   endtask

   task automatic do_req(input bit wr, input logic [ROW_W-1:0] row,
                         input logic [COL_W-1:0] col, input logic [DW-1:0] wd,
                         output int t_req);
      @(negedge clk); #1;
      clear_mon();
      t_req = cyc;
      req_valid = 1'b1; req_write = wr; req_addr = {row, col}; req_wdata = wd;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk); #1;
         if (n_ack > 0) break;
      end
      req_valid = 1'b0;
      repeat (CL + 2) @(negedge clk);
      #1;
   endtask

   task automatic t_reset_state();
      for (int i = 0; i < 3; i++) begin
         @(negedge clk); #1;
         chk("R1 R13 bus idle NOP", int'(bus_cmd), int'(C_NOP));
         chk("R1 ack low", int'(req_ack), 0);
         chk("R1 rd_valid low", int'(rd_valid), 0);
         chk("R1 dq_oe low", int'(sd_dq_oe), 0);
      end
   endtask

   task automatic t_empty_read();
      int tr;
      do_req(1'b0, 12'h012, 8'h34, 16'h0, tr);
      chk("R4 no PRECHARGE when empty", n_pre, 0);
      chk("R4 ACTIVATE next cycle", t_act - tr, 1);
      chk("R8 ACTIVATE row on bus", int'(a_act), 'h012);
      chk("R5 ACT to READ gap", t_col - t_act, TRCD);
      chk("R13 READ code", int'(c_col), int'(C_RD));
      chk("R8 column on bus A10 low", int'(a_col), 'h034);
      chk("R12 ack with column", t_ack - t_col, 0);
      chk("R12 one ack", n_ack, 1);
      chk("R6 one rd_valid", n_rv, 1);
      chk("R6 CAS latency", t_rv - t_col, CL);
      chk("R6 read data", int'(d_rd), int'(16'hA500 + 16'(t_rv)));
   endtask

   task automatic t_hit_write();
      int tr;
      do_req(1'b1, 12'h012, 8'hFF, 16'hBEEF, tr);
      chk("R2 hit column next cycle", t_col - tr, 1);
      chk("R2 no ACTIVATE on hit", n_act, 0);
      chk("R2 no PRECHARGE on hit", n_pre, 0);
      chk("R13 WRITE code", int'(c_col), int'(C_WR));
      chk("R7 write data on bus", int'(d_wr), 'hBEEF);
      chk("R7 dq_oe with WRITE", int'(oe_wr), 1);
      chk("R7 dq_oe only with WRITE", oe_bad, 0);
      chk("R8 column address", int'(a_col), 'h0FF);
      chk("R12 single column command", n_col, 1);
      chk("R12 no read return for write", n_rv, 0);
      chk("R12 ack matches column", ack_bad, 0);
   endtask

   task automatic t_hit_read();
      int tr;
      do_req(1'b0, 12'h012, 8'h07, 16'h0, tr);
      chk("R2 hit read next cycle", t_col - tr, 1);
      chk("R2 no ACTIVATE on hit read", n_act, 0);
      chk("R6 hit read latency", t_rv - t_col, CL);
      chk("R6 hit read data", int'(d_rd), int'(16'hA500 + 16'(t_rv)));
   endtask

   task automatic t_miss_read();
      int tr;
      do_req(1'b0, 12'h3A5, 8'h11, 16'h0, tr);
      chk("R3 PRECHARGE next cycle", t_pre - tr, 1);
      chk("R3 R13 one PRECHARGE", n_pre, 1);
      chk("R3 miss PRECHARGE A10 low", int'(a10_pre), 0);
      chk("R3 PRE to ACT gap", t_act - t_pre, TRP);
      chk("R3 new row activated", int'(a_act), 'h3A5);
      chk("R3 ACT to READ gap", t_col - t_act, TRCD);
      chk("R12 READ for read request", int'(c_col), int'(C_RD));
   endtask

   task automatic t_miss_write_a10();
      int tr;
      do_req(1'b1, 12'h400, 8'h55, 16'h1234, tr);
      chk("R3 miss write PRECHARGE", t_pre - tr, 1);
      chk("R8 row with bit10 on ACTIVATE", int'(a_act), 'h400);
      chk("R8 column clears A10", int'(a_col), 'h055);
      chk("R7 miss write data", int'(d_wr), 'h1234);
      chk("R5 miss write tRCD", t_col - t_act, TRCD);
   endtask

   task automatic t_refresh_period();
      @(negedge clk); #1;
      clear_mon();
      for (int i = 0; i < 300; i++) begin
         @(negedge clk); #1;
         if (n_ref >= 2) break;
      end
      chk("R9 two refreshes seen", n_ref, 2);
      chk("R9 refresh period", t_ref - t_ref_prev, REF_D + 1);
      chk("R10 no PRECHARGE with no open row", n_pre, 0);
   endtask

   task automatic t_refresh_hold();
      int tr, target;
      target = t_ref - 1 + (REF_D + 1);
      while (cyc < target - 1) begin
         @(negedge clk); #1;
      end
      do_req(1'b0, 12'h0AB, 8'h01, 16'h0, tr);
      chk("R11 request placed on pending cycle", tr, target);
      chk("R11 refresh wins", t_ref - tr, 1);
      chk("R11 ACTIVATE after tRFC", t_act - t_ref, TRFC);
      chk("R11 read completes", n_ack, 1);
      chk("R10 quiet during tRFC", rfc_bad, 0);
   endtask

   task automatic t_refresh_open_row();
      int tr;
      @(negedge clk); #1;
      clear_mon();
      for (int i = 0; i < 200; i++) begin
         @(negedge clk); #1;
         if (n_ref >= 1) break;
      end
      chk("R10 all-bank PRECHARGE issued", n_pre, 1);
      chk("R10 all-bank PRECHARGE A10 high", int'(a10_pre), 1);
      chk("R10 PRE to REFRESH gap", t_ref - t_pre, TRP);
      repeat (TRFC + 1) @(negedge clk);
      #1;
      chk("R10 quiet after refresh", rfc_bad, 0);
      do_req(1'b0, 12'h0AB, 8'h02, 16'h0, tr);
      chk("R10 row closed: ACTIVATE", n_act, 1);
      chk("R10 row closed: no PRECHARGE", n_pre, 0);
   endtask

   initial begin
      do_reset(16'd60000);
      t_reset_state();
      t_empty_read();
      t_hit_write();
      t_hit_read();
      t_miss_read();
      t_miss_write_a10();
      do_reset(16'(REF_D));
      t_refresh_period();
      t_refresh_hold();
      t_refresh_open_row();
      summary();
      $finish;
   end

endmodule